// File: doc/BRIEF.md
# Bad-Block Mark Swap and Chunk Status Tally

This unit post-processes a page buffer that sits next to an ECC engine. The engine packs data and parity into a layout in which the flash's factory bad-block marker position falls somewhere inside the data area. That position is often not byte aligned. The unit exchanges the eight bits found at that position with the first metadata byte, so the marker always ends up in metadata byte 0. The exchange is its own inverse, so the same operation prepares a page before programming and restores it after reading.

After a read, the unit also walks the per-chunk status bytes that the ECC engine left behind the metadata. It tallies them into a corrected-bit total and a failed-chunk count. The unit reaches the buffer through a single byte-wide port with a one-cycle read latency. The mark byte address, the bit offset, the metadata base and the chunk count are all inputs; it computes none of them.

A pulse on `start` launches one operation. `busy` stays high until a one-cycle `done` pulse marks the end.

Top module: `mark_swap_ecc_stat`

## Requirements
- R1: After reset, `busy` and `done` are low and both counters are zero.
- R2: The byte written to the metadata base is bits [bit+7:bit] of the 16-bit value {buf[off+1], buf[off]}, where bit is `mark_bit`.
- R3: In buf[off], bits below `mark_bit` keep their old value. Bits from `mark_bit` upward receive the low (8 - `mark_bit`) bits of the old metadata byte.
- R4: In buf[off+1], bits from `mark_bit` upward keep their old value. The low `mark_bit` bits receive the top `mark_bit` bits of the old metadata byte. With `mark_bit` = 0, buf[off+1] is not written at all.
- R5: Running the operation twice with the same inputs restores the original buffer contents.
- R6: In read mode (`rd_mode` = 1), there is one status byte per chunk for `n_chunks` chunks. These bytes are read starting at the metadata base plus the metadata size rounded up to a multiple of 4, which is 12 for 10 metadata bytes. With `n_chunks` = 0, no status byte is read.
- R7: Status codes 0x00 (clean) and 0xFF (erased) leave both counters unchanged.
- R8: Status code 0xFE (uncorrectable) adds one to `fail_cnt`.
- R9: Any other status value is added to `corr_cnt`.
- R10: Counters clear at each start. In write mode (`rd_mode` = 0), no status is scanned and the counters stay zero.
- R11: `done` is a one-cycle pulse. It appears with `busy` already low, after the swap and after the last status byte. A `start` pulse while `busy` is high is ignored.
- R12: The only bytes the unit writes are off, off+1 and the metadata base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one operation when idle |
| rd_mode | input | 1 | 1 = swap then tally chunk status; 0 = swap only |
| mark_off | input | AW | Buffer address of the low byte holding the mark |
| mark_bit | input | 3 | Bit offset of the mark inside `mark_off` |
| meta_base | input | AW | Buffer address of metadata byte 0 |
| n_chunks | input | CW | Number of chunk status bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| corr_cnt | output | CW+8 | Sum of corrected-bit counts |
| fail_cnt | output | CW+8 | Number of uncorrectable chunks |
| mem_addr | output | AW | Buffer byte address |
| mem_we | output | 1 | Buffer write enable |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, valid one cycle after the address |

## Verification
The hardest case to reach from the ports is a bit offset whose two halves of the merged byte must land in different buffer bytes. The particular hazard is the zero-offset case, where the upper byte must not be touched at all. The stimulus therefore sweeps all eight bit offsets against pseudo-random neighbour, mark and metadata bytes. For each one it checks the bytes just outside the pair, then repeats the operation to confirm the buffer returns to its original state. Status tallies are driven with mixes that deliberately place the reserved codes 0x00, 0xFE and 0xFF among ordinary counts, over chunk counts from zero to the maximum.

// File: rtl/mark_swap_ecc_stat.sv
module mark_swap_ecc_stat #(
  parameter int AW = 12,
  parameter int CW = 4,
  parameter int META_BYTES = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_mode,
  input  logic [AW-1:0] mark_off,
  input  logic [2:0]    mark_bit,
  input  logic [AW-1:0] meta_base,
  input  logic [CW-1:0] n_chunks,
  output logic          busy,
  output logic          done,
  output logic [CW+7:0] corr_cnt,
  output logic [CW+7:0] fail_cnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int STAT_OFF = ((META_BYTES + 3) / 4) * 4;
  localparam int SW = CW + 8;

  typedef enum logic [3:0] {IDLE, RA, RB, RM, RW, WA, WB, WM, SCAN, LAST} st_t;
  st_t st;

  logic [AW-1:0] off_q, meta_q;
  logic [2:0]    bit_q;
  logic [CW-1:0] n_q, idx;
  logic          rd_q, rv;
  logic [7:0]    b0, b1, m;

  wire [15:0] pair   = {b1, b0};
  wire [15:0] mask   = 16'h00ff << bit_q;
  wire [15:0] merged = (pair & ~mask) | ({8'h00, m} << bit_q);
  wire [15:0] shr    = pair >> bit_q;
  wire [7:0]  src    = shr[7:0];

  assign busy = (st != IDLE);

  always_comb begin
    case (st)
      RB, WB:  mem_addr = off_q + AW'(1);
      RM, WM:  mem_addr = meta_q;
      SCAN:    mem_addr = meta_q + AW'(STAT_OFF) + AW'(idx);
      default: mem_addr = off_q;
    endcase
  end

  assign mem_we    = (st == WA) || (st == WM) || ((st == WB) && (bit_q != 3'd0));
  assign mem_wdata = (st == WA) ? merged[7:0] : (st == WB) ? merged[15:8] : src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; rv <= 1'b0;
      corr_cnt <= '0; fail_cnt <= '0;
      off_q <= '0; meta_q <= '0; bit_q <= '0; n_q <= '0; rd_q <= 1'b0;
      idx <= '0; b0 <= '0; b1 <= '0; m <= '0;
    end else begin
      done <= 1'b0;
      rv   <= (st == SCAN);
      if (rv) begin
        if (mem_rdata == 8'hfe) fail_cnt <= fail_cnt + SW'(1);
        else if (mem_rdata != 8'h00 && mem_rdata != 8'hff)
          corr_cnt <= corr_cnt + SW'(mem_rdata);
      end
      case (st)
        IDLE: if (start) begin
          off_q <= mark_off; bit_q <= mark_bit; meta_q <= meta_base;
          n_q <= n_chunks; rd_q <= rd_mode;
          corr_cnt <= '0; fail_cnt <= '0;
          st <= RA;
        end
        RA: st <= RB;
        RB: begin b0 <= mem_rdata; st <= RM; end
        RM: begin b1 <= mem_rdata; st <= RW; end
        RW: begin m  <= mem_rdata; st <= WA; end
        WA: st <= WB;
        WB: st <= WM;
        WM: begin
          idx <= '0;
          if (rd_q && n_q != '0) st <= SCAN;
          else begin st <= IDLE; done <= 1'b1; end
        end
        SCAN: begin
          if (idx == n_q - CW'(1)) st <= LAST;
          else idx <= idx + CW'(1);
        end
        LAST: begin st <= IDLE; done <= 1'b1; end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mark_swap_ecc_stat_chk.sv
module mark_swap_ecc_stat_chk #(
  parameter int AW = 12,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] off_q,
  input logic [2:0]    bit_q,
  input logic [CW+7:0] corr_cnt,
  input logic [CW+7:0] fail_cnt
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R12
  we_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy);
  // R4
  bit0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_we && bit_q == 3'd0) |-> (mem_addr != off_q + AW'(1)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(corr_cnt) && $stable(fail_cnt)));
  // R8
  fail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (fail_cnt == $past(fail_cnt) || fail_cnt == $past(fail_cnt) + (CW+8)'(1)));
endmodule

bind mark_swap_ecc_stat mark_swap_ecc_stat_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_addr(mem_addr), .off_q(off_q), .bit_q(bit_q),
  .corr_cnt(corr_cnt), .fail_cnt(fail_cnt)
);

// File: tb/sim_mark_swap_ecc_stat.sv
module sim_mark_swap_ecc_stat;
  localparam int AW = 12, CW = 4;
  localparam logic [AW-1:0] META = 12'h800;

  logic clk = 0, rst_n = 0, start = 0, rd_mode = 0;
  logic [AW-1:0] mark_off = '0, meta_base = META;
  logic [2:0] mark_bit = '0;
  logic [CW-1:0] n_chunks = '0;
  logic busy, done, mem_we;
  logic [CW+7:0] corr_cnt, fail_cnt;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [0:(1<<AW)-1];

  int checks = 0, errors = 0, cycles = 0;
  int seed = 32'h1234_5678;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  mark_swap_ecc_stat #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
    .mark_off(mark_off), .mark_bit(mark_bit), .meta_base(meta_base),
    .n_chunks(n_chunks), .busy(busy), .done(done), .corr_cnt(corr_cnt),
    .fail_cnt(fail_cnt), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  function automatic logic [7:0] rnd();
    seed = seed * 1103515245 + 12345;
    return seed[23:16];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(logic rd, logic [AW-1:0] off, logic [2:0] b,
                        logic [CW-1:0] n, bit poke);
    @(negedge clk);
    rd_mode = rd; mark_off = off; mark_bit = b; n_chunks = n; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      mark_off = off + 12'h40; mark_bit = b + 3'd1; rd_mode = ~rd; start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int t = 0; t < 100 && !done; t++) @(negedge clk);
    chk("R11 done seen", done, 1);
    chk("R11 busy low at done", busy, 0);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
  endtask

  initial begin
    logic [7:0] b0, b1, mm, pm, nx, e0, e1, em, s;
    int ec, ef;
    logic [AW-1:0] off;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h5a;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 corr", corr_cnt, 0); chk("R1 fail", fail_cnt, 0);
    rst_n = 1;

    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 6; k++) begin
        off = 12'h100 + 12'(b * 32 + k * 4);
        pm = rnd(); b0 = rnd(); b1 = rnd(); nx = rnd(); mm = rnd();
        mem[off-1] = pm; mem[off] = b0; mem[off+1] = b1; mem[off+2] = nx;
        mem[META] = mm; mem[META+1] = 8'hc3;
        run_op(1'b0, off, 3'(b), 4'd5, (b == 3 && k == 1));
        e0 = (b0 & ((8'h1 << b) - 8'h1)) | 8'(mm << b);
        e1 = (b == 0) ? b1 : ((b1 & ~((8'h1 << b) - 8'h1)) | (mm >> (8 - b)));
        em = 8'((({8'h0, b1} << 8) | b0) >> b);
        chk("R2 meta byte", mem[META], em);
        chk("R3 low byte", mem[off], e0);
        chk("R4 high byte", mem[off+1], e1);
        chk("R12 below pair", mem[off-1], pm);
        chk("R12 above pair", mem[off+2], nx);
        chk("R12 meta+1", mem[META+1], 8'hc3);
        chk("R10 write mode corr", corr_cnt, 0);
        chk("R10 write mode fail", fail_cnt, 0);
        // second pass in read mode: restores buffer and tallies status
        ec = 0; ef = 0;
        for (int c = 0; c < 16; c++) begin
          case (rnd() % 4)
            0: s = 8'h00; 1: s = 8'hff; 2: s = 8'hfe;
            default: s = rnd() % 8'hf0 + 8'h01;
          endcase
          mem[META + 12 + c] = s;
          if (c < (b * 6 + k) % 16) begin
            if (s == 8'hfe) ef++;
            else if (s != 8'h00 && s != 8'hff) ec += s;
          end
        end
        run_op(1'b1, off, 3'(b), 4'((b * 6 + k) % 16), 1'b0);
        chk("R5 restore low", mem[off], b0);
        chk("R5 restore high", mem[off+1], b1);
        chk("R5 restore meta", mem[META], mm);
        chk("R6 R7 R9 corrected", corr_cnt, ec);
        chk("R6 R8 failed", fail_cnt, ef);
      end
    end

    // R7 R8 R9 explicit mix over 15 chunks
    for (int c = 0; c < 15; c++)
      mem[META + 12 + c] = (c % 5 == 0) ? 8'h00 : (c % 5 == 1) ? 8'hff :
                           (c % 5 == 2) ? 8'hfe : 8'(c);
    mem[META + 11] = 8'h07; mem[META + 27] = 8'h09;
    run_op(1'b1, 12'h300, 3'd2, 4'd15, 1'b0);
    chk("R9 corrected mix", corr_cnt, 3+4+8+9+13+14);
    chk("R8 failed mix", fail_cnt, 3);
    // R6 zero chunks reads nothing
    run_op(1'b1, 12'h300, 3'd2, 4'd0, 1'b0);
    chk("R6 zero chunks corr", corr_cnt, 0);
    chk("R6 zero chunks fail", fail_cnt, 0);
    // R10 idle counters hold
    repeat (5) @(negedge clk);
    chk("R10 idle hold", fail_cnt, 0);
    summary();
  end
endmodule